// File: doc/BRIEF.md
# Sliced Video Data Capture FIFO

This block buffers bytes that a line slicer recovers from the blanking interval of a video signal, such as caption characters or aspect-ratio signalling. Each byte arrives with a one-cycle write strobe and is stored in a byte-wide queue. The fill level is reported in 16-bit words, where two stored bytes make one word. An interrupt level is raised while that word count is above a programmable threshold.

Three configuration locations sit on a small register write port: the threshold, a flush trigger and a consumer select. Writing any value to the flush location empties the queue. The same write clears the overflow flag and four latched side-data registers (caption, widescreen, timecode and program-system). No second write is needed to end the flush. The consumer select bit picks who drains the queue: either the 8-bit video output path or the host read port. The other consumer's pop requests are ignored.

Top module: `vbi_capture_fifo`

## Requirements
- R1: After synchronous reset, fill_words is 0 and irq, overflow, host_rvalid, vid_valid and every bit of side_q are 0.
- R2: Every accepted byte raises the stored byte count by one. fill_words is the stored byte count divided by two, rounded down, and changes on the clock edge that accepts the byte.
- R3: The queue holds 512 bytes. A byte strobed in while 512 bytes are stored is dropped and leaves the count unchanged. overflow goes to 1 on that edge and stays at 1 until a flush or reset.
- R4: irq is 1 exactly when the fill_words value of the previous cycle was strictly greater than the threshold. It returns to 0 one cycle after the count falls to the threshold or below.
- R5: Writing cfg_addr 0 sets the 8-bit threshold. Its reset value is 0x80, so irq rises at 129 words and not at 128.
- R6: A write of any data to cfg_addr 1 empties the queue, clears overflow, clears all four side-data slots and cancels any read result due. The flush needs no second write: a byte written on the next cycle is stored normally.
- R7: cfg_addr 2 bit 0 selects the consumer. 0 (reset value) selects the video path (vid_pop, vid_data, vid_valid) and 1 selects the host port (host_rd, host_rdata, host_rvalid). A pop by the selected consumer returns the oldest byte on the next cycle, with its valid set to 1.
- R8: A pop by the consumer that is not selected returns nothing and leaves fill_words and the read order unchanged.
- R9: A pop while the queue is empty returns no valid data.
- R10: side_we[i] loads side_din into slot i of side_q (slot i at bits 16*i+15 down to 16*i). The slots are 0 caption, 1 widescreen, 2 timecode and 3 program-system.
- R11: A write and a pop accepted on the same edge leave the byte count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Byte write strobe from the slicer |
| wr_byte | input | 8 | Sliced byte |
| side_we | input | 4 | Per-slot load strobes for side-data registers |
| side_din | input | 16 | Side-data value to load |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 threshold, 1 flush, 2 consumer select |
| cfg_wdata | input | 8 | Configuration write data |
| host_rd | input | 1 | Host pop request |
| host_rdata | output | 8 | Host read byte, 0 when not valid |
| host_rvalid | output | 1 | Host read byte valid |
| vid_pop | input | 1 | Video path pop request |
| vid_data | output | 8 | Video path byte, 0 when not valid |
| vid_valid | output | 1 | Video path byte valid |
| fill_words | output | 9 | Stored bytes divided by two |
| irq | output | 1 | Threshold interrupt level |
| overflow | output | 1 | Sticky dropped-byte flag |
| side_q | output | 64 | Four 16-bit side-data slots |

## Verification
Counts, overflow, flush effects and side-data loads are due on the clock edge that takes the stimulus. Read data and its valid are due one cycle after the pop edge. irq is due one cycle after fill_words changes. Inputs are driven on the falling edge. The count, flag and read-data checks sample at the next falling edge, and every irq check waits one extra idle cycle first. In this way each result is observed in the cycle it is due, and never one cycle early by accident.

// File: rtl/vbi_fifo_pkg.sv
package vbi_fifo_pkg;
  typedef enum logic [1:0] {
    CFG_THRESH = 2'd0,
    CFG_FLUSH  = 2'd1,
    CFG_OSEL   = 2'd2
  } cfg_addr_e;

  typedef enum logic {
    SRC_VIDEO = 1'b0,
    SRC_HOST  = 1'b1
  } rd_src_e;

  localparam int SIDE_SLOTS = 4;
endpackage

// File: rtl/vbi_fifo_cfg.sv
module vbi_fifo_cfg
  import vbi_fifo_pkg::*;
#(
  parameter int              CFG_W   = 8,
  parameter logic [CFG_W-1:0] THR_RST = 'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] thr_q,
  output rd_src_e          osel_q,
  output logic             flush_o
);
  // flush is a pulse decoded from the write itself: nothing to clear later
  assign flush_o = cfg_we && (cfg_addr == CFG_FLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= THR_RST;
      osel_q <= SRC_VIDEO;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_THRESH) thr_q  <= cfg_wdata;
      if (cfg_addr == CFG_OSEL)   osel_q <= rd_src_e'(cfg_wdata[0]);
    end
  end

  p_thr_default_r5: assert property (@(posedge clk)
    rst |=> (thr_q == THR_RST));
endmodule

// File: rtl/vbi_fifo_store.sv
module vbi_fifo_store
  import vbi_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop_req,
  input  rd_src_e                  pop_src,
  output logic [$clog2(DEPTH):0]   cnt_q,
  output logic                     ovf_q,
  output logic [DW-1:0]            rd_data_q,
  output logic                     rd_valid_q,
  output rd_src_e                  rd_src_q
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == FULL);
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  rd_data_q   <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      cnt_q      <= '0;
      ovf_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_src_q   <= SRC_VIDEO;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push && full) ovf_q <= 1'b1;
      rd_valid_q <= pop_ok;
      if (pop_ok) rd_src_q <= pop_src;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !flush) |=> ovf_q);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_req && !flush) |=> (cnt_q == FULL) && ovf_q);
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0) && !ovf_q && !rd_valid_q);
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push) |=> !rd_valid_q);
  p_push_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (push && pop_req && !empty && !full && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/vbi_side_regs.sv
module vbi_side_regs #(
  parameter int SW = 16,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [N-1:0]  side_we,
  input  logic [SW-1:0] side_din,
  output logic [N*SW-1:0] side_q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush)    side_q[i*SW +: SW] <= '0;
      else if (side_we[i]) side_q[i*SW +: SW] <= side_din;
    end
  end

  p_side_clear_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (side_q == '0));
endmodule

// File: rtl/vbi_capture_fifo.sv
module vbi_capture_fifo
  import vbi_fifo_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 512,
  parameter int SIDE_W = 16,
  parameter int CFG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic [DW-1:0]                 wr_byte,
  input  logic [SIDE_SLOTS-1:0]         side_we,
  input  logic [SIDE_W-1:0]             side_din,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_addr,
  input  logic [CFG_W-1:0]              cfg_wdata,
  input  logic                          host_rd,
  output logic [DW-1:0]                 host_rdata,
  output logic                          host_rvalid,
  input  logic                          vid_pop,
  output logic [DW-1:0]                 vid_data,
  output logic                          vid_valid,
  output logic [$clog2(DEPTH)-1:0]      fill_words,
  output logic                          irq,
  output logic                          overflow,
  output logic [SIDE_SLOTS*SIDE_W-1:0]  side_q
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int WW = CW - 1;

  logic [CFG_W-1:0] thr_q;
  rd_src_e          osel_q, rd_src_q;
  logic             flush;
  logic             pop_req;
  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    rd_data_q;
  logic             rd_valid_q;

  vbi_fifo_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .thr_q(thr_q), .osel_q(osel_q), .flush_o(flush)
  );

  assign pop_req = (osel_q == SRC_HOST) ? host_rd : vid_pop;

  vbi_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(wr_valid), .push_data(wr_byte),
    .pop_req(pop_req), .pop_src(osel_q), .cnt_q(cnt_q), .ovf_q(overflow),
    .rd_data_q(rd_data_q), .rd_valid_q(rd_valid_q), .rd_src_q(rd_src_q)
  );

  vbi_side_regs #(.SW(SIDE_W), .N(SIDE_SLOTS)) u_side (
    .clk(clk), .rst(rst), .flush(flush), .side_we(side_we),
    .side_din(side_din), .side_q(side_q)
  );

  assign fill_words  = cnt_q[CW-1:1];
  assign host_rvalid = rd_valid_q && (rd_src_q == SRC_HOST);
  assign vid_valid   = rd_valid_q && (rd_src_q == SRC_VIDEO);
  assign host_rdata  = host_rvalid ? rd_data_q : '0;
  assign vid_data    = vid_valid   ? rd_data_q : '0;

  // compare registered count against registered threshold: one flop deep
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (fill_words > WW'(thr_q));
  end

  p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(fill_words) > WW'($past(thr_q)))));
  p_ignore_host_r8: assert property (@(posedge clk) disable iff (rst)
    (osel_q == SRC_VIDEO) |=> !host_rvalid);
  p_ignore_vid_r8: assert property (@(posedge clk) disable iff (rst)
    (osel_q == SRC_HOST) |=> !vid_valid);
endmodule

// File: tb/vbi_capture_fifo_tb.sv
`timescale 1ns/1ps
module vbi_capture_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [3:0]  side_we = '0;
  logic [15:0] side_din = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        vid_pop = 1'b0;
  logic [7:0]  vid_data;
  logic        vid_valid;
  logic [8:0]  fill_words;
  logic        irq;
  logic        overflow;
  logic [63:0] side_q;

  always #2 clk = ~clk;

  vbi_capture_fifo u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .side_we(side_we), .side_din(side_din), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .vid_pop(vid_pop),
    .vid_data(vid_data), .vid_valid(vid_valid), .fill_words(fill_words),
    .irq(irq), .overflow(overflow), .side_q(side_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model[$];
  logic [7:0] seq = 8'h11;

  // vector: kind(2) n(10) expected words(9) expected irq(1)
  // kind 0 push n, 1 video pop n, 2 threshold=n, 3 flush
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {2'd2, 10'd2,   9'd0,   1'b0},
    {2'd0, 10'd5,   9'd2,   1'b0},
    {2'd0, 10'd1,   9'd3,   1'b1},
    {2'd1, 10'd1,   9'd2,   1'b0},
    {2'd2, 10'd1,   9'd2,   1'b1},
    {2'd3, 10'd0,   9'd0,   1'b0},
    {2'd2, 10'd128, 9'd0,   1'b0},
    {2'd0, 10'd258, 9'd129, 1'b1},
    {2'd1, 10'd2,   9'd128, 1'b0},
    {2'd3, 10'd0,   9'd0,   1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 2'd1) model.delete();
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_byte = seq;
      if (model.size() < 512) model.push_back(seq);
      seq = seq + 8'd1;
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic pop_vid(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = model.pop_front();
      vid_pop = 1'b1;
      @(negedge clk);
      check({tag, " vid_valid"}, vid_valid, 1);
      check({tag, " vid_data"}, vid_data, e);
    end
    vid_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 fill_words", fill_words, 0);
    check("R1 irq", irq, 0);
    check("R1 overflow", overflow, 0);
    check("R1 host_rvalid", host_rvalid, 0);
    check("R1 vid_valid", vid_valid, 0);
    check("R1 side_q", side_q, 0);

    // R2 R4 table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] k;
      int n;
      k = VEC[v][21:20];
      n = int'(VEC[v][19:10]);
      case (k)
        2'd0: push(n);
        2'd1: pop_vid(n, "R7 table");
        2'd2: cfg_write(2'd0, n[7:0]);
        default: cfg_write(2'd1, 8'hC3);
      endcase
      @(negedge clk);
      check($sformatf("R2 vec%0d fill_words", v), fill_words, VEC[v][9:1]);
      check($sformatf("R4 vec%0d irq", v), irq, VEC[v][0]);
    end

    // R5 default threshold after reset
    rst = 1'b1; model.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    push(256); @(negedge clk);
    check("R5 irq at 128 words", irq, 0);
    push(2); @(negedge clk);
    check("R5 irq at 129 words", irq, 1);

    // R3 overflow
    push(254);
    check("R3 full words", fill_words, 256);
    check("R3 no overflow yet", overflow, 0);
    push(1);
    check("R3 overflow set", overflow, 1);
    check("R3 words unchanged", fill_words, 256);
    pop_vid(1, "R3 drop order");
    check("R3 overflow sticky", overflow, 1);
    push(1);
    check("R3 refill words", fill_words, 256);

    // R6 flush
    cfg_write(2'd1, 8'h00);
    check("R6 flush words", fill_words, 0);
    check("R6 flush overflow", overflow, 0);
    push(2);
    check("R6 self-clearing store", fill_words, 1);

    // R11 simultaneous push and pop
    begin
      logic [7:0] e;
      e = model.pop_front();
      model.push_back(seq);
      wr_valid = 1'b1; wr_byte = seq; seq = seq + 8'd1; vid_pop = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; vid_pop = 1'b0;
      check("R11 words stable", fill_words, 1);
      check("R11 data", vid_data, e);
    end

    // R7 R8 consumer select
    cfg_write(2'd2, 8'h01);
    vid_pop = 1'b1; @(negedge clk); vid_pop = 1'b0;
    check("R8 vid ignored valid", vid_valid, 0);
    check("R8 vid ignored words", fill_words, 1);
    begin
      logic [7:0] e;
      e = model.pop_front();
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
      check("R7 host valid", host_rvalid, 1);
      check("R7 host data", host_rdata, e);
      check("R7 host no vid", vid_valid, 0);
    end
    cfg_write(2'd2, 8'h00);
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    check("R8 host ignored valid", host_rvalid, 0);
    check("R8 host ignored words", fill_words, 0);
    pop_vid(1, "R8 order kept");

    // R9 pop when empty
    cfg_write(2'd1, 8'hFF);
    vid_pop = 1'b1; @(negedge clk); vid_pop = 1'b0;
    check("R9 empty pop valid", vid_valid, 0);
    check("R9 empty pop words", fill_words, 0);

    // R10 side slots, then R6 clears them
    for (int s = 0; s < 4; s++) begin
      side_we = 4'(1 << s); side_din = 16'hA000 + 16'(s);
      @(negedge clk);
    end
    side_we = '0;
    for (int s = 0; s < 4; s++)
      check($sformatf("R10 slot%0d", s), side_q[s*16 +: 16], 16'hA000 + 16'(s));
    cfg_write(2'd1, 8'h01);
    check("R6 side cleared", side_q, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule